// File: doc/BRIEF.md
# Two-Layer Alpha Compositor

This block merges up to two stacked image layers over a constant background colour, one pixel at a time. The background sits at the bottom, layer 0 is composited over it, and layer 1 is composited over that intermediate result. Every layer has its own enable, an 8-bit global alpha, a switch that makes the global alpha replace the pixel's own alpha, and two 4-bit selectors. One selector picks the weight applied to the layer pixel and the other picks the weight applied to the colour beneath it.

Pixels and controls arrive together under a single valid strobe, and there is no backpressure. The pipeline has three register stages: input capture, the layer 0 merge and the layer 1 merge. It produces one composited pixel for each accepted input, and valid travels alongside the data. Pixel fetch, format unpacking, decompression and serial output formatting belong to neighbouring blocks.

Top module: `alpha_mix_top`

## Requirements
- R1: Every 32-bit pixel is packed as red [31:24], green [23:16], blue [15:8], alpha [7:0]. Stacking is background, then layer 0, then layer 1. Layer 1 is merged with the layer 0 result as its destination.
- R2: When both layers are disabled, the output pixel equals the background input exactly.
- R3: For each of the four channels, an enabled layer produces sat(src·Fs + dst·Fd). The alpha channel uses the effective source alpha as its src value. Fs comes from the source selector and Fd from the destination selector, with these codes: 4'b0000 gives 0, 4'b0001 gives 255, 4'b0010 gives source alpha, 4'b0011 gives global alpha, 4'b0100 gives source alpha × global alpha, 4'b0101 gives 255 − source alpha, 4'b0110 gives 255 − global alpha, 4'b0111 gives 255 − (source alpha × global alpha), 4'b1010 gives destination alpha (the alpha of the colour beneath), and 4'b1101 gives 255 − destination alpha.
- R4: Any selector code outside the ten listed in R3 acts as factor 0.
- R5: When a layer's force bit is set, its global alpha replaces the pixel alpha everywhere the source alpha is used, including the alpha channel that is written out.
- R6: With selectors source-alpha / inverse-source-alpha, a layer alpha of 0x00 yields the colour beneath unchanged and 0xFF yields the layer pixel.
- R7: Each channel sum saturates at 255.
- R8: Every 8×8 fractional product a·b is computed as t = a·b + 128, result = (t + (t >> 8)) >> 8.
- R9: A pixel sampled with the valid input high at clock edge N is on the outputs after edge N+2, with the output valid high. The output valid follows the input valid pattern with the same delay, bubbles included.
- R10: Reset clears the output valid and the output pixel to 0. While the output valid is low, the output pixel keeps its last value.
- R11: A disabled layer passes the colour beneath it through untouched, whatever its pixel, alpha and selector inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs below carry a pixel this cycle |
| bg_color | input | 32 | Background colour |
| l0_pixel | input | 32 | Layer 0 pixel |
| l0_en | input | 1 | Layer 0 enable |
| l0_force_ga | input | 1 | Layer 0: global alpha replaces pixel alpha |
| l0_galpha | input | 8 | Layer 0 global alpha |
| l0_src_sel | input | 4 | Layer 0 source factor code |
| l0_dst_sel | input | 4 | Layer 0 destination factor code |
| l1_pixel | input | 32 | Layer 1 pixel |
| l1_en | input | 1 | Layer 1 enable |
| l1_force_ga | input | 1 | Layer 1: global alpha replaces pixel alpha |
| l1_galpha | input | 8 | Layer 1 global alpha |
| l1_src_sel | input | 4 | Layer 1 source factor code |
| l1_dst_sel | input | 4 | Layer 1 destination factor code |
| out_valid | output | 1 | Composited pixel valid |
| out_pixel | output | 32 | Composited pixel |

## Verification
The bench builds the block with its default parameters: 8-bit channels, four channels and two layers. The full 8-bit range of the fractional multiply is therefore reachable, covering the exact endpoints 0 and 255, the rounding midpoints and the saturation overflow of the channel sum. With two layers, the sweep can pair every one of the sixteen source codes with every destination code on the top layer while the lower layer runs random settings. That sweep exercises destination alpha coming from a real intermediate blend rather than from the background alone.

// File: rtl/alpha_mix_pkg.sv
package alpha_mix_pkg;

    localparam int CH_W       = 8;
    localparam int NUM_CH     = 4;
    localparam int NUM_LAYERS = 2;
    localparam int SEL_W      = 4;
    localparam int PIX_W      = CH_W * NUM_CH;
    localparam int PROD_W     = 2 * CH_W + 1;

    typedef logic [CH_W-1:0] chan_t;

    // alpha in the low byte, red in the high byte
    typedef struct packed {
        chan_t red;
        chan_t green;
        chan_t blue;
        chan_t alpha;
    } pixel_t;

    typedef enum logic [SEL_W-1:0] {
        FAC_ZERO        = 4'b0000,
        FAC_ONE         = 4'b0001,
        FAC_SRC_A       = 4'b0010,
        FAC_GLB_A       = 4'b0011,
        FAC_SRC_X_GLB   = 4'b0100,
        FAC_INV_SRC     = 4'b0101,
        FAC_INV_GLB     = 4'b0110,
        FAC_INV_SRC_GLB = 4'b0111,
        FAC_DST_A       = 4'b1010,
        FAC_INV_DST     = 4'b1101
    } factor_e;

    typedef struct packed {
        logic              en;
        logic              force_ga;
        chan_t             galpha;
        logic [SEL_W-1:0]  src_sel;
        logic [SEL_W-1:0]  dst_sel;
    } layer_ctl_t;

    typedef struct packed {
        pixel_t     pix;
        layer_ctl_t ctl;
    } layer_in_t;

    // fractional product with 255 meaning 1.0, rounded
    function automatic chan_t frac_mul(chan_t a, chan_t b);
        logic [PROD_W-1:0] t;
        logic [PROD_W-1:0] u;
        t = PROD_W'(a) * PROD_W'(b) + PROD_W'(1 << (CH_W - 1));
        u = (t + (t >> CH_W)) >> CH_W;
        return u[CH_W-1:0];
    endfunction

    function automatic chan_t factor_pick(logic [SEL_W-1:0] sel,
                                          chan_t a_src, chan_t a_glb, chan_t a_dst);
        chan_t r;
        case (sel)
            FAC_ONE:         r = '1;
            FAC_SRC_A:       r = a_src;
            FAC_GLB_A:       r = a_glb;
            FAC_SRC_X_GLB:   r = frac_mul(a_src, a_glb);
            FAC_INV_SRC:     r = ~a_src;
            FAC_INV_GLB:     r = ~a_glb;
            FAC_INV_SRC_GLB: r = ~frac_mul(a_src, a_glb);
            FAC_DST_A:       r = a_dst;
            FAC_INV_DST:     r = ~a_dst;
            default:         r = '0;
        endcase
        return r;
    endfunction

    function automatic chan_t sat_add(chan_t x, chan_t y);
        logic [CH_W:0] s;
        s = {1'b0, x} + {1'b0, y};
        return s[CH_W] ? '1 : s[CH_W-1:0];
    endfunction

endpackage

// File: rtl/alpha_mix_channel.sv
module alpha_mix_channel
    import alpha_mix_pkg::*;
(
    input  chan_t src_c,
    input  chan_t dst_c,
    input  chan_t fac_s,
    input  chan_t fac_d,
    output chan_t mix_c
);
    assign mix_c = sat_add(frac_mul(src_c, fac_s), frac_mul(dst_c, fac_d));
endmodule

// File: rtl/alpha_mix_stage.sv
module alpha_mix_stage
    import alpha_mix_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  pixel_t                      dst_pix,
    input  layer_in_t [NUM_LAYERS-1:0]  in_bundle,
    output logic                        out_valid,
    output pixel_t                      out_pix,
    output layer_in_t [NUM_LAYERS-1:0]  out_bundle
);
    layer_in_t         cur;
    chan_t             a_eff;
    chan_t             fs;
    chan_t             fd;
    logic [PIX_W-1:0]  src_vec;
    logic [PIX_W-1:0]  dst_vec;
    logic [PIX_W-1:0]  mix_vec;
    pixel_t            result;

    assign cur     = in_bundle[IDX];
    assign a_eff   = cur.ctl.force_ga ? cur.ctl.galpha : cur.pix.alpha;
    assign fs      = factor_pick(cur.ctl.src_sel, a_eff, cur.ctl.galpha, dst_pix.alpha);
    assign fd      = factor_pick(cur.ctl.dst_sel, a_eff, cur.ctl.galpha, dst_pix.alpha);
    assign src_vec = {cur.pix.red, cur.pix.green, cur.pix.blue, a_eff};
    assign dst_vec = dst_pix;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        alpha_mix_channel u_ch (
            .src_c (src_vec[ch*CH_W +: CH_W]),
            .dst_c (dst_vec[ch*CH_W +: CH_W]),
            .fac_s (fs),
            .fac_d (fd),
            .mix_c (mix_vec[ch*CH_W +: CH_W])
        );
    end

    assign result = cur.ctl.en ? pixel_t'(mix_vec) : dst_pix;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_pix    <= '0;
            out_bundle <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_pix    <= result;
                out_bundle <= in_bundle;
            end
        end
    end
endmodule

// File: rtl/alpha_mix_top.sv
module alpha_mix_top
    import alpha_mix_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] bg_color,
    input  logic [31:0] l0_pixel,
    input  logic        l0_en,
    input  logic        l0_force_ga,
    input  logic [7:0]  l0_galpha,
    input  logic [3:0]  l0_src_sel,
    input  logic [3:0]  l0_dst_sel,
    input  logic [31:0] l1_pixel,
    input  logic        l1_en,
    input  logic        l1_force_ga,
    input  logic [7:0]  l1_galpha,
    input  logic [3:0]  l1_src_sel,
    input  logic [3:0]  l1_dst_sel,
    output logic        out_valid,
    output logic [31:0] out_pixel
);
    layer_in_t [NUM_LAYERS-1:0] port_bun;
    logic                       chain_v   [NUM_LAYERS+1];
    pixel_t                     chain_pix [NUM_LAYERS+1];
    layer_in_t [NUM_LAYERS-1:0] chain_bun [NUM_LAYERS+1];

    assign port_bun[0] = {l0_pixel, l0_en, l0_force_ga, l0_galpha, l0_src_sel, l0_dst_sel};
    assign port_bun[1] = {l1_pixel, l1_en, l1_force_ga, l1_galpha, l1_src_sel, l1_dst_sel};

    // capture stage
    always_ff @(posedge clk) begin
        if (rst) begin
            chain_v[0]   <= 1'b0;
            chain_pix[0] <= '0;
            chain_bun[0] <= '0;
        end else begin
            chain_v[0] <= in_valid;
            if (in_valid) begin
                chain_pix[0] <= bg_color;
                chain_bun[0] <= port_bun;
            end
        end
    end

    for (genvar i = 0; i < NUM_LAYERS; i++) begin : g_layer
        alpha_mix_stage #(.IDX(i)) u_stage (
            .clk        (clk),
            .rst        (rst),
            .in_valid   (chain_v[i]),
            .dst_pix    (chain_pix[i]),
            .in_bundle  (chain_bun[i]),
            .out_valid  (chain_v[i+1]),
            .out_pix    (chain_pix[i+1]),
            .out_bundle (chain_bun[i+1])
        );
    end

    assign out_valid = chain_v[NUM_LAYERS];
    assign out_pixel = chain_pix[NUM_LAYERS];
endmodule

// File: rtl/alpha_mix_top_chk.sv
module alpha_mix_top_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] bg_color,
    input logic        l0_en,
    input logic [31:0] l1_pixel,
    input logic        l1_en,
    input logic        l1_force_ga,
    input logic [3:0]  l1_src_sel,
    input logic [3:0]  l1_dst_sel,
    input logic        out_valid,
    input logic [31:0] out_pixel
);
    logic [1:0] seen;

    always_ff @(posedge clk) begin
        if (rst) seen <= 2'd0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        (seen == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    p_bg_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (seen == 2'd3 && out_valid && $past(!l0_en && !l1_en, 3))
        |-> (out_pixel == $past(bg_color, 3)));

    p_top_opaque_r1: assert property (@(posedge clk) disable iff (rst)
        (seen == 2'd3 && out_valid &&
         $past(l1_en && !l1_force_ga && l1_src_sel == 4'b0001 && l1_dst_sel == 4'b0000, 3))
        |-> (out_pixel == $past(l1_pixel, 3)));

    p_undef_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (seen == 2'd3 && out_valid &&
         $past(l1_en && l1_src_sel == 4'b1000 && l1_dst_sel == 4'b1000, 3))
        |-> (out_pixel == 32'h0));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (seen != 2'd0 && !out_valid) |-> $stable(out_pixel));

endmodule

bind alpha_mix_top alpha_mix_top_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .bg_color    (bg_color),
    .l0_en       (l0_en),
    .l1_pixel    (l1_pixel),
    .l1_en       (l1_en),
    .l1_force_ga (l1_force_ga),
    .l1_src_sel  (l1_src_sel),
    .l1_dst_sel  (l1_dst_sel),
    .out_valid   (out_valid),
    .out_pixel   (out_pixel)
);

// File: tb/alpha_mix_top_bench.sv
module alpha_mix_top_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] bg_color, l0_pixel, l1_pixel;
    logic        l0_en, l0_force_ga, l1_en, l1_force_ga;
    logic [7:0]  l0_galpha, l1_galpha;
    logic [3:0]  l0_src_sel, l0_dst_sel, l1_src_sel, l1_dst_sel;
    logic        out_valid;
    logic [31:0] out_pixel;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        bit          v;
        logic [31:0] p;
        string       tag;
    } exp_t;
    exp_t        exp_q[$];
    logic [31:0] last_pix = 32'h0;

    always #4 clk = ~clk;

    alpha_mix_top u_alpha_mix_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .bg_color(bg_color),
        .l0_pixel(l0_pixel), .l0_en(l0_en), .l0_force_ga(l0_force_ga),
        .l0_galpha(l0_galpha), .l0_src_sel(l0_src_sel), .l0_dst_sel(l0_dst_sel),
        .l1_pixel(l1_pixel), .l1_en(l1_en), .l1_force_ga(l1_force_ga),
        .l1_galpha(l1_galpha), .l1_src_sel(l1_src_sel), .l1_dst_sel(l1_dst_sel),
        .out_valid(out_valid), .out_pixel(out_pixel)
    );

    // ---------------- reference model ----------------
    function automatic int rmul(int a, int b);
        int t;
        t = a * b + 128;
        return (t + (t >> 8)) >> 8;
    endfunction

    function automatic int rfac(int sel, int as_, int ag, int ad);
        case (sel)
            1:  return 255;
            2:  return as_;
            3:  return ag;
            4:  return rmul(as_, ag);
            5:  return 255 - as_;
            6:  return 255 - ag;
            7:  return 255 - rmul(as_, ag);
            10: return ad;
            13: return 255 - ad;
            default: return 0;
        endcase
    endfunction

    function automatic bit code_defined(int sel);
        return (sel <= 7) || sel == 10 || sel == 13;
    endfunction

    // ctl = {en, force, galpha[7:0], src[3:0], dst[3:0]}
    function automatic logic [31:0] rlayer(logic [31:0] dst, logic [31:0] src, logic [17:0] c);
        logic [31:0] res;
        int as_, fs, fd, sv, dv, r;
        if (!c[17]) return dst;
        as_ = c[16] ? int'(c[15:8]) : int'(src[7:0]);
        fs  = rfac(int'(c[7:4]), as_, int'(c[15:8]), int'(dst[7:0]));
        fd  = rfac(int'(c[3:0]), as_, int'(c[15:8]), int'(dst[7:0]));
        for (int ch = 0; ch < 4; ch++) begin
            sv = (ch == 0) ? as_ : int'(src[ch*8 +: 8]);
            dv = int'(dst[ch*8 +: 8]);
            r  = rmul(sv, fs) + rmul(dv, fd);
            if (r > 255) r = 255;
            res[ch*8 +: 8] = 8'(r);
        end
        return res;
    endfunction

    function automatic logic [17:0] mk(bit en, bit frc, int ga, int ss, int ds);
        return {en, frc, 8'(ga), 4'(ss), 4'(ds)};
    endfunction

    // ---------------- checking ----------------
    task automatic check_out();
        exp_t e;
        if (exp_q.size() == 3) begin
            e = exp_q.pop_front();
            checks++;
            if (out_valid !== e.v) begin
                errors++;
                $display("FAIL %s (R9 valid): out_valid=%0b expected %0b", e.tag, out_valid, e.v);
            end
            checks++;
            if (e.v) begin
                if (out_pixel !== e.p) begin
                    errors++;
                    $display("FAIL %s: out_pixel=%08h expected %08h", e.tag, out_pixel, e.p);
                end
                last_pix = e.p;
            end else if (out_pixel !== last_pix) begin
                errors++;
                $display("FAIL R10 hold: out_pixel=%08h expected %08h", out_pixel, last_pix);
            end
        end
    endtask

    task automatic cycle(bit v, logic [31:0] bg, logic [31:0] p0, logic [17:0] c0,
                         logic [31:0] p1, logic [17:0] c1, string tag);
        exp_t e;
        @(negedge clk);
        check_out();
        in_valid = v; bg_color = bg;
        l0_pixel = p0; {l0_en, l0_force_ga, l0_galpha, l0_src_sel, l0_dst_sel} = c0;
        l1_pixel = p1; {l1_en, l1_force_ga, l1_galpha, l1_src_sel, l1_dst_sel} = c1;
        e.v = v;
        e.p = rlayer(rlayer(bg, p0, c0), p1, c1);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; bg_color = '0; l0_pixel = '0; l1_pixel = '0;
        {l0_en, l0_force_ga, l0_galpha, l0_src_sel, l0_dst_sel} = '0;
        {l1_en, l1_force_ga, l1_galpha, l1_src_sel, l1_dst_sel} = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        checks++;
        if (out_valid !== 1'b0 || out_pixel !== 32'h0) begin
            errors++;
            $display("FAIL R10 reset: valid=%0b pixel=%08h expected 0 00000000", out_valid, out_pixel);
        end
        rst = 1'b0;

        // R2: no layer enabled (selectors non-zero to show they are ignored)
        for (int k = 0; k < 4; k++)
            cycle(1, $urandom, $urandom, mk(0, 1, $urandom, 1, 0), $urandom, mk(0, 0, 9, 1, 1), "R2");

        // R11: layer 0 disabled under an enabled top layer, and the reverse
        cycle(1, 32'h11223344, 32'hFFFFFFFF, mk(0, 0, 0, 1, 1), 32'h80402010, mk(1, 0, 0, 1, 0), "R11");
        cycle(1, 32'h11223344, 32'h5566AA00, mk(1, 0, 0, 2, 5), 32'h80402010, mk(0, 1, 255, 1, 1), "R11");
        cycle(1, 32'h10203040, 32'h55667788, mk(1, 0, 0, 1, 0), 32'hAABBCC99, mk(0, 0, 0, 1, 0), "R11");

        // R1: stacking order
        cycle(1, 32'h00000000, 32'h204060FF, mk(1, 0, 0, 1, 0), 32'hE0C0A080, mk(1, 0, 0, 2, 5), "R1");
        cycle(1, 32'h0A0B0C0D, 32'h12345678, mk(1, 0, 0, 1, 0), 32'h9ABCDEF0, mk(1, 0, 0, 1, 0), "R1");
        cycle(1, 32'hFF0000FF, 32'h00FF0040, mk(1, 0, 0, 2, 13), 32'h0000FFC0, mk(1, 0, 0, 10, 13), "R1");

        // R3 / R4: full selector sweep on layer 1 over random layer 0
        for (int ss = 0; ss < 16; ss++)
            for (int ds = 0; ds < 16; ds++)
                cycle(1, $urandom, $urandom, mk(1, $urandom % 2, $urandom, $urandom % 16, $urandom % 16),
                      $urandom, mk(1, $urandom % 2, $urandom, ss, ds),
                      (code_defined(ss) && code_defined(ds)) ? "R3" : "R4");
        cycle(1, 32'hFFFFFFFF, 32'h0, mk(0, 0, 0, 0, 0), 32'hFFFFFFFF, mk(1, 0, 0, 8, 8), "R4");
        cycle(1, 32'hFFFFFFFF, 32'h0, mk(0, 0, 0, 0, 0), 32'hFFFFFFFF, mk(1, 0, 0, 15, 11), "R4");

        // R5: forced global alpha
        cycle(1, 32'h20406080, 32'hFFFFFF00, mk(1, 1, 255, 2, 5), 32'h0, mk(0, 0, 0, 0, 0), "R5");
        cycle(1, 32'h20406080, 32'hC0C0C0FF, mk(1, 1, 64, 2, 5), 32'h0, mk(0, 0, 0, 0, 0), "R5");
        cycle(1, 32'h20406080, 32'h10203040, mk(1, 0, 0, 1, 0), 32'hFFFFFFFF, mk(1, 1, 0, 2, 5), "R5");

        // R6: transparent and opaque layer pixels
        cycle(1, 32'h13579BDF, 32'hFFEEDD00, mk(1, 0, 0, 2, 5), 32'h0, mk(0, 0, 0, 0, 0), "R6");
        cycle(1, 32'h13579BDF, 32'hFFEEDDFF, mk(1, 0, 0, 2, 5), 32'h0, mk(0, 0, 0, 0, 0), "R6");
        cycle(1, 32'h13579BDF, 32'h0, mk(0, 0, 0, 0, 0), 32'h24681357, mk(1, 1, 255, 2, 5), "R6");

        // R7: saturation
        cycle(1, 32'hC0C0C0C0, 32'hC0C0C0C0, mk(1, 0, 0, 1, 1), 32'h0, mk(0, 0, 0, 0, 0), "R7");
        cycle(1, 32'hFF01FF01, 32'h01FF01FF, mk(1, 0, 0, 1, 1), 32'h0, mk(0, 0, 0, 0, 0), "R7");

        // R8: rounding of fractional products
        for (int g = 0; g < 256; g += 17)
            cycle(1, 32'h0, 32'h80FF0181, mk(1, 0, g, 3, 0), 32'h0, mk(0, 0, 0, 0, 0), "R8");
        cycle(1, 32'h0, 32'h7F7F7F80, mk(1, 1, 128, 4, 0), 32'h0, mk(0, 0, 0, 0, 0), "R8");

        // R9 / R10: bubbles with changing data on idle cycles
        for (int k = 0; k < 24; k++)
            cycle((k % 3) != 1, $urandom, $urandom, mk(1, 0, $urandom, 2, 5),
                  $urandom, mk($urandom % 2, 0, $urandom, 3, 6), "R9");

        // drain the pipeline
        for (int k = 0; k < 4; k++)
            cycle(0, $urandom, $urandom, '0, $urandom, '0, "R10");

        finish_run();
    end

endmodule